// File: doc/BRIEF.md
# Tagged Sample Capture Buffer

This block holds converter samples in an on-chip queue while waveform capture is switched on. Each accepted sample is packed into one 32-bit word with three parts: the 16-bit converter code, the 4-bit channel identifier, and an 11-bit sample-number timestamp. A host drains the queue one word at a time. The head word is always present on the read data output, and a read strobe removes it. The fill level and an empty flag are visible to the host at all times.

The host programs a notification level. While the number of stored words is at or above that level, a level-sensitive interrupt request is raised. Once reads bring the count below the level, the request drops. Samples that arrive while the queue is full are discarded, and a sticky overflow flag records the loss. Clearing the store-enable flag empties the queue and clears the overflow flag. Any per-channel latest-value registers are kept outside this block and keep updating whether capture is on or off.

A small control machine tracks occupancy with three named states:
- `ST_OFF`: capture is disabled and the queue is flushed.
- `ST_FILL`: capture is enabled and there is room in the queue.
- `ST_FULL`: the count equals the depth, so new samples are dropped.

The state transitions are:
- OFF→FILL, or OFF→FULL when the depth is 1, when the store flag rises.
- FILL→FULL when a write brings the count to the depth.
- FULL→FILL when a read frees a slot.
- Any state→OFF when the store flag is low.

Top module: `smp_capture_fifo`

## Requirements
- R1: Each stored word is packed as follows: bits 31:21 hold the sample number, bit 20 is 0, bits 19:16 hold the channel ID, and bits 15:0 hold the code.
- R2: A sample is stored only in a cycle where both `smp_valid` and `store_en` are 1. Valid samples presented while `store_en` is 0 leave the count at 0.
- R3: Words are read in arrival order. `rd_data` shows the oldest stored word whenever `empty` is 0. A pulse on `rd_stb` removes that word in the next clock. `rd_stb` while the queue is empty has no effect.
- R4: `fill_count` equals writes minus reads since the last flush, and `empty` is 1 exactly when it is 0. A write and a read in the same cycle leave the count unchanged.
- R5: The queue holds at most 2046 words. A sample offered when the count is 2046 is discarded, even if a read happens in the same cycle.
- R6: `ovf_flag` goes to 1 in the clock after a sample is discarded. It then stays at 1 until `store_en` is 0.
- R7: `irq` is 1 exactly while `fill_count` is at or above the effective threshold. For example, with a threshold of 0x3FF, `irq` rises after the 1023rd sample and falls when a read takes the count to 1022.
- R8: A threshold of 0, or of any value above 2046, acts as 2046.
- R9: One clock with `store_en` at 0 empties the queue: `fill_count` becomes 0 and `empty` becomes 1 in the next cycle.
- R10: After reset, `fill_count` is 0, `empty` is 1, and both `irq` and `ovf_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample present this cycle |
| smp_code | input | 16 | Converter code |
| smp_chan | input | 4 | Channel identifier |
| smp_num | input | 11 | Sample-number timestamp |
| store_en | input | 1 | Capture enable; when low, the queue is flushed |
| thresh | input | 11 | Interrupt level, in words |
| rd_stb | input | 1 | Pop the head word |
| rd_data | output | 32 | Packed head word |
| fill_count | output | 11 | Number of stored words |
| empty | output | 1 | Queue holds no words |
| irq | output | 1 | Level interrupt request |
| ovf_flag | output | 1 | Sticky flag: a sample was dropped |

## Verification
The bench fills the queue to exactly 2046 words and keeps offering samples, including in a cycle that also reads. A design that frees the slot early would accept a word it should drop, and the count and data order would then disagree with the model. The interrupt is checked at both edges of the 0x3FF example and with clamped thresholds of 0 and 2047. An off-by-one compare would fire a cycle early or late, and a missing clamp would never fire. The bench also reads while empty, pushes samples with capture off, and flushes after overflow. A design that wrapped its count, stored samples while disabled, or kept a stale overflow flag would be caught by the per-cycle comparison.

// File: rtl/smpcap_pkg.sv
package smpcap_pkg;

    localparam int CODE_W = 16;
    localparam int CHAN_W = 4;
    localparam int NUM_W  = 11;
    localparam int WORD_W = NUM_W + 1 + CHAN_W + CODE_W;

    // Bit layout of one stored entry, most significant field first.
    typedef struct packed {
        logic [NUM_W-1:0]  num;
        logic              rsvd;
        logic [CHAN_W-1:0] chan;
        logic [CODE_W-1:0] code;
    } smp_word_t;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_FILL = 2'd1,
        ST_FULL = 2'd2
    } cap_state_t;

    function automatic smp_word_t pack_smp(
        input logic [CODE_W-1:0] code,
        input logic [CHAN_W-1:0] chan,
        input logic [NUM_W-1:0]  num
    );
        smp_word_t w;
        w.num  = num;
        w.rsvd = 1'b0;
        w.chan = chan;
        w.code = code;
        return w;
    endfunction

endpackage

// File: rtl/smpcap_store.sv
module smpcap_store #(
    parameter int DEPTH  = 2046,
    parameter int WORD_W = 32,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [WORD_W-1:0] rdata
);

    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/smpcap_ctrl.sv
module smpcap_ctrl
    import smpcap_pkg::*;
#(
    parameter int DEPTH  = 2046,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             store_en,
    input  logic             smp_valid,
    input  logic             rd_stb,
    output logic             wr_en,
    output logic [AW-1:0]    wr_ptr,
    output logic [AW-1:0]    rd_ptr,
    output logic [CNT_W-1:0] count,
    output logic             ovf
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [AW-1:0]    LAST_PTR = AW'(DEPTH - 1);

    cap_state_t       state_q, state_d;
    logic [AW-1:0]    wp_q, rp_q;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             ovf_q;
    logic             wr_ok, rd_ok, drop;

    // Output / action decode from the current state.
    always_comb begin
        wr_ok = 1'b0;
        rd_ok = 1'b0;
        drop  = 1'b0;
        unique case (state_q)
            ST_OFF: begin
                wr_ok = store_en && smp_valid;
            end
            ST_FILL: begin
                wr_ok = store_en && smp_valid;
                rd_ok = store_en && rd_stb && (cnt_q != '0);
            end
            ST_FULL: begin
                rd_ok = store_en && rd_stb;
                drop  = store_en && smp_valid;
            end
            default: begin
                wr_ok = 1'b0;
            end
        endcase
        cnt_d = cnt_q + CNT_W'(wr_ok) - CNT_W'(rd_ok);
    end

    // Next-state decode.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (store_en) begin
                    state_d = (cnt_d == FULL_CNT) ? ST_FULL : ST_FILL;
                end
            end
            ST_FILL: begin
                if (!store_en) begin
                    state_d = ST_OFF;
                end else if (cnt_d == FULL_CNT) begin
                    state_d = ST_FULL;
                end
            end
            ST_FULL: begin
                if (!store_en) begin
                    state_d = ST_OFF;
                end else if (rd_ok) begin
                    state_d = ST_FILL;
                end
            end
            default: state_d = ST_OFF;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Pointer, count and overflow registers.
    always_ff @(posedge clk) begin
        if (!rst_n || !store_en) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            if (wr_ok) begin
                wp_q <= (wp_q == LAST_PTR) ? '0 : wp_q + AW'(1);
            end
            if (rd_ok) begin
                rp_q <= (rp_q == LAST_PTR) ? '0 : rp_q + AW'(1);
            end
            cnt_q <= cnt_d;
            if (drop) begin
                ovf_q <= 1'b1;
            end
        end
    end

    assign wr_en  = wr_ok;
    assign wr_ptr = wp_q;
    assign rd_ptr = rp_q;
    assign count  = cnt_q;
    assign ovf    = ovf_q;

endmodule

// File: rtl/smpcap_irq.sv
module smpcap_irq #(
    parameter int DEPTH  = 2046,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] thresh,
    output logic             irq
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [CNT_W-1:0] level;

    always_comb begin
        if (thresh == '0 || thresh > FULL_CNT) begin
            level = FULL_CNT;
        end else begin
            level = thresh;
        end
        irq = (count >= level);
    end

endmodule

// File: rtl/smp_capture_fifo.sv
module smp_capture_fifo
    import smpcap_pkg::*;
#(
    parameter int DEPTH  = 2046,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 smp_valid,
    input  logic [CODE_W-1:0]    smp_code,
    input  logic [CHAN_W-1:0]    smp_chan,
    input  logic [NUM_W-1:0]     smp_num,
    input  logic                 store_en,
    input  logic [CNT_W-1:0]     thresh,
    input  logic                 rd_stb,
    output logic [WORD_W-1:0]    rd_data,
    output logic [CNT_W-1:0]     fill_count,
    output logic                 empty,
    output logic                 irq,
    output logic                 ovf_flag
);

    logic          wr_en;
    logic [AW-1:0] wr_ptr, rd_ptr;
    smp_word_t     wr_word;

    assign wr_word = pack_smp(smp_code, smp_chan, smp_num);

    smpcap_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .store_en  (store_en),
        .smp_valid (smp_valid),
        .rd_stb    (rd_stb),
        .wr_en     (wr_en),
        .wr_ptr    (wr_ptr),
        .rd_ptr    (rd_ptr),
        .count     (fill_count),
        .ovf       (ovf_flag)
    );

    smpcap_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_store (
        .clk   (clk),
        .we    (wr_en),
        .waddr (wr_ptr),
        .wdata (wr_word),
        .raddr (rd_ptr),
        .rdata (rd_data)
    );

    smpcap_irq #(.DEPTH(DEPTH)) u_irq (
        .count  (fill_count),
        .thresh (thresh),
        .irq    (irq)
    );

    assign empty = (fill_count == '0);

endmodule

// File: rtl/smpcap_chk.sv
module smpcap_chk #(
    parameter int DEPTH  = 2046,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             smp_valid,
    input logic             store_en,
    input logic             rd_stb,
    input logic [CNT_W-1:0] fill_count,
    input logic             empty,
    input logic             ovf_flag
);

    // R5
    cap_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_count <= CNT_W'(DEPTH));

    // R5
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (store_en && smp_valid && !rd_stb && fill_count == CNT_W'(DEPTH))
        |=> (fill_count == CNT_W'(DEPTH)));

    // R9
    flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !store_en |=> (fill_count == '0 && empty && !ovf_flag));

    // R6
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && store_en) |=> ovf_flag);

    // R2
    no_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (store_en && !smp_valid && !rd_stb) |=> $stable(fill_count));

    // R4
    pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (store_en && rd_stb && !empty && !smp_valid)
        |=> (fill_count == $past(fill_count) - CNT_W'(1)));

endmodule

bind smp_capture_fifo smpcap_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .smp_valid  (smp_valid),
    .store_en   (store_en),
    .rd_stb     (rd_stb),
    .fill_count (fill_count),
    .empty      (empty),
    .ovf_flag   (ovf_flag)
);

// File: tb/smp_capture_fifo_tb.sv
module smp_capture_fifo_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 2046;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_code = '0;
    logic [3:0]  smp_chan = '0;
    logic [10:0] smp_num = '0;
    logic        store_en = 1'b0;
    logic [10:0] thresh = '0;
    logic        rd_stb = 1'b0;
    logic [31:0] rd_data;
    logic [10:0] fill_count;
    logic        empty, irq, ovf_flag;

    int n_chk  = 0;
    int n_fail = 0;
    int seq    = 0;

    logic [31:0] mq[$];
    logic        m_ovf = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    smp_capture_fifo u_dut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_code(smp_code),
        .smp_chan(smp_chan), .smp_num(smp_num), .store_en(store_en),
        .thresh(thresh), .rd_stb(rd_stb), .rd_data(rd_data),
        .fill_count(fill_count), .empty(empty), .irq(irq), .ovf_flag(ovf_flag)
    );

    // Behavioural reference: updated on every rising edge.
    always @(posedge clk) begin
        if (!rst_n || !store_en) begin
            mq.delete();
            m_ovf = 1'b0;
        end else begin
            automatic bit was_full = (mq.size() == DEPTH);
            if (rd_stb && mq.size() > 0) void'(mq.pop_front());
            if (smp_valid) begin
                if (was_full) m_ovf = 1'b1;
                else mq.push_back({smp_num, 1'b0, smp_chan, smp_code});
            end
        end
    end

    function automatic int eff_level(input int t);
        return (t == 0 || t > DEPTH) ? DEPTH : t;
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison against the model.
    task automatic compare();
        chk(fill_count == 11'(mq.size()), "R4 fill_count", fill_count, mq.size());
        chk(empty == (mq.size() == 0), "R4 empty", empty, mq.size() == 0);
        chk(irq == (mq.size() >= eff_level(int'(thresh))), "R7 irq", irq,
            mq.size() >= eff_level(int'(thresh)));
        chk(ovf_flag == m_ovf, "R6 ovf_flag", ovf_flag, m_ovf);
        if (mq.size() > 0)
            chk(rd_data == mq[0], "R1 R3 rd_data", rd_data, mq[0]);
    endtask

    task automatic step(input bit v, input bit rd);
        @(negedge clk);
        compare();
        smp_valid = v;
        rd_stb    = rd;
        smp_code  = 16'(seq * 37 + 5);
        smp_chan  = 4'(seq);
        smp_num   = 11'(seq * 3);
        if (v) seq++;
    endtask

    task automatic settle();
        step(1'b0, 1'b0);
        @(negedge clk);
        compare();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R10 reset state
        chk(fill_count == 0 && empty && !irq && !ovf_flag, "R10 reset",
            {fill_count, empty, irq, ovf_flag}, 14'b1_0_0);
        rst_n = 1'b1;

        // R2: samples with capture off are not stored
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
        settle();
        chk(fill_count == 0, "R2 store disabled", fill_count, 0);

        // R1 R3 R4 R7: basic fill, low threshold, mixed traffic
        store_en = 1'b1;
        thresh = 11'd3;
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
        settle();
        chk(irq == 1'b1, "R7 above threshold", irq, 1);
        chk(rd_data == {11'(0 * 3 + 15), 1'b0, 4'(5), 16'(5 * 37 + 5)},
            "R1 packed head", rd_data, {11'(15), 1'b0, 4'(5), 16'(190)});
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1);
        settle();
        chk(fill_count == 2 && !irq, "R7 below threshold", {fill_count, irq}, {11'd2, 1'b0});
        for (int i = 0; i < 6; i++) step(1'b1, 1'b1);
        settle();
        chk(fill_count == 2, "R4 simultaneous rw", fill_count, 2);

        // R9 flush
        store_en = 1'b0;
        settle();
        chk(fill_count == 0 && empty, "R9 flush", fill_count, 0);
        store_en = 1'b1;

        // R7 example level 0x3FF
        thresh = 11'h3FF;
        for (int i = 0; i < 1022; i++) step(1'b1, 1'b0);
        settle();
        chk(!irq, "R7 1022 below", irq, 0);
        step(1'b1, 1'b0);
        settle();
        chk(irq, "R7 1023 reached", irq, 1);
        step(1'b0, 1'b1);
        settle();
        chk(!irq, "R7 drop after read", irq, 0);

        // R8 R5 R6: clamp, fill to capacity and overflow
        thresh = 11'd0;
        for (int i = 0; i < DEPTH - 1022 - 1; i++) step(1'b1, 1'b0);
        settle();
        chk(fill_count == 11'(DEPTH - 1) && !irq, "R8 one short", fill_count, DEPTH - 1);
        step(1'b1, 1'b0);
        settle();
        chk(fill_count == 11'(DEPTH) && irq && !ovf_flag, "R5 full", fill_count, DEPTH);
        step(1'b1, 1'b0);
        step(1'b1, 1'b1);
        settle();
        chk(fill_count == 11'(DEPTH - 1) && ovf_flag, "R5 R6 drop", {fill_count, ovf_flag},
            {11'(DEPTH - 1), 1'b1});
        thresh = 11'd2047;
        settle();
        chk(!irq, "R8 above depth", irq, 0);
        step(1'b1, 1'b0);
        settle();
        chk(irq, "R8 clamp 2047", irq, 1);

        // R3 drain and read past empty
        for (int i = 0; i < DEPTH + 4; i++) step(1'b0, 1'b1);
        settle();
        chk(fill_count == 0 && empty, "R3 read while empty", fill_count, 0);
        chk(ovf_flag, "R6 sticky", ovf_flag, 1);
        store_en = 1'b0;
        settle();
        chk(!ovf_flag, "R6 R9 cleared", ovf_flag, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule